// File: doc/BRIEF.md
# Smart Card Character Transceiver with Automatic Resend

This block moves single characters across the one-wire, half-duplex data line of an asynchronous smart card link that uses the character-oriented T=0 protocol. The line is open-drain: the block only pulls it low or lets it float, and reads the resolved level back. Each character occupies ten elementary time units (ETUs): a low start bit, eight data bits sent least significant first, and an even parity bit. An error-signal window follows each character.

In transmit mode the host writes a byte, and the block frames it and watches the window after the parity bit. If the card pulls the line low there, the block flags the error and sends the same character again after the guard time. The transmit-end flag is raised only once a character gets through with no error. In receive mode the block detects a start bit, samples each bit at mid-bit, and checks parity. On good parity it hands the byte to the host. On bad parity it flags the error and pulls the line low in the window so that the card resends.

Timing comes from a one-cycle `sampleTick` enable that pulses `OVS` times per ETU. Sticky status flags are cleared by single-cycle clear strobes, and each interrupt output is its flag gated by an enable input.

Top module: `card_link_xcvr`

## Requirements
- R1: In transmit mode a character is put on the line as a low start bit, then data bits 0 to 7 (least significant first), then the parity bit. Each bit lasts `OVS` ticks. The block drives the line only low (`lineLow`=1) or released, and is released whenever it sends a 1.
- R2: The parity bit makes the number of ones across the eight data bits and the parity bit even, both when sending and when checking a received character.
- R3: In transmit mode the block samples the line 11 ETUs after its start bit began. A low level there sets `errRecv`, and `irqErr` is high while `errRecv` or `parityErr` is set and `ieErr` is 1.
- R4: A character that drew an error signal is sent again, with identical bits, starting 14 ETUs after the start of the failed attempt. `txEnd` stays low through every failed attempt.
- R5: A character with no error signal in its window leaves `errRecv` unchanged. `txEnd` is set 14 ETUs after that attempt's start bit, and `busy` then falls. `irqTxEnd` equals `txEnd` gated by `ieTxEnd`. An accepted `txStart` clears `txEnd`.
- R6: A one-cycle pulse on `clrErrRecv`, `clrParityErr` or `clrRxFull` clears the matching flag. A set event in the same cycle wins.
- R7: In receive mode a character with good parity loads `rxData` (bit 0 = first data bit), sets `rxFull`, and keeps the line released through the error window. `irqRx` equals `rxFull` gated by `ieRx`.
- R8: In receive mode a character with bad parity sets `parityErr`, leaves `rxFull` and `rxData` untouched, and pulls the line low from 10.5 to 11.5 ETUs after the start was detected.
- R9: While idle the line is released. `txStart` has no effect while `busy` is 1 or while `txMode` is 0.
- R10: In receive mode, a low level that is gone by the middle of the start bit is discarded. The block returns to idle and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Oversampling enable, `OVS` pulses per ETU |
| txMode | input | 1 | 1 selects transmit mode, 0 selects receive mode |
| txStart | input | 1 | One-cycle strobe: send `txData` |
| txData | input | 8 | Byte to send |
| rxData | output | 8 | Last byte received with good parity |
| busy | output | 1 | A character or its window/guard is in progress |
| lineIn | input | 1 | Resolved level of the shared data line |
| lineLow | output | 1 | 1 pulls the shared line low, 0 releases it |
| clrErrRecv | input | 1 | Clear strobe for `errRecv` |
| clrParityErr | input | 1 | Clear strobe for `parityErr` |
| clrRxFull | input | 1 | Clear strobe for `rxFull` |
| errRecv | output | 1 | Error signal seen after a transmitted character |
| parityErr | output | 1 | Received character failed parity |
| rxFull | output | 1 | `rxData` holds a new byte |
| txEnd | output | 1 | Character delivered without error |
| ieErr | input | 1 | Enable for `irqErr` |
| ieTxEnd | input | 1 | Enable for `irqTxEnd` |
| ieRx | input | 1 | Enable for `irqRx` |
| irqErr | output | 1 | Error interrupt request |
| irqTxEnd | output | 1 | Transmit-end interrupt request |
| irqRx | output | 1 | Receive-data interrupt request |

## Verification
A wrong sub-ETU or ETU count shifts the mid-bit sample points or the error window. This shows within one character as a wrong byte at the card model, a missed or spurious error signal, or `busy` still high 12.5 ETUs after a received start. A retry flag that is stuck or lost shows one slot (14 ETUs) later: a second frame after a clean character, or a missing resend and an early `txEnd`. A mis-latched frame register shows as resent bits that differ from the first attempt. A bad parity tree shows in the same character, either as a wrong parity bit on the line or as a wrong choice between `rxFull` and `parityErr`.

// File: rtl/card_link_pkg.sv
package card_link_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } linkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;   // restart sub-ETU and ETU counters
    logic cntStep;    // advance counters by one tick
    logic loadTx;     // latch host byte into the frame register
    logic capBit;     // store the line level as a received data bit
    logic commitRx;   // move received bits to the host data register
  } dpStrobes_t;

endpackage

// File: rtl/card_link_dp.sv
module card_link_dp
  import card_link_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int ETU_W = 4,
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       stb,
  input  logic [7:0]       txData,
  input  logic             lineIn,
  output logic [SUB_W-1:0] subCnt,
  output logic [ETU_W-1:0] etuCnt,
  output logic             txBitLevel,
  output logic             rxParityOk,
  output logic [7:0]       rxData
);

  localparam int SLOTS = 2 ** ETU_W;

  logic [9:0]       frameReg;
  logic [SLOTS-1:0] frameBits;
  logic [8:1]       rxBits;

  // bit clock: sub-ETU counter rolls into the ETU counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt <= '0;
      etuCnt <= '0;
    end else if (stb.cntClear) begin
      subCnt <= '0;
      etuCnt <= '0;
    end else if (stb.cntStep) begin
      if (subCnt == SUB_W'(OVS - 1)) begin
        subCnt <= '0;
        etuCnt <= etuCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  // frame register: parity, data, start (start bit in position 0)
  always_ff @(posedge clk) begin
    if (!rstN) frameReg <= '1;
    else if (stb.loadTx) frameReg <= {^txData, txData, 1'b0};
  end

  // slots past the parity bit read as released
  assign frameBits  = {{(SLOTS - 10){1'b1}}, frameReg};
  assign txBitLevel = frameBits[etuCnt];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBits <= '0;
      rxData <= '0;
    end else begin
      if (stb.capBit)   rxBits[etuCnt] <= lineIn;
      if (stb.commitRx) rxData <= rxBits;
    end
  end

  // evaluated while the parity bit is on the line
  assign rxParityOk = ~(^rxBits ^ lineIn);

endmodule

// File: rtl/card_link_ctrl.sv
module card_link_ctrl
  import card_link_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int GUARD_ETU = 2,
  parameter int ETU_W     = 4,
  parameter int SUB_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             txMode,
  input  logic             txStart,
  input  logic             lineIn,
  input  logic             clrErrRecv,
  input  logic             clrParityErr,
  input  logic             clrRxFull,
  input  logic             ieErr,
  input  logic             ieTxEnd,
  input  logic             ieRx,
  input  logic [SUB_W-1:0] subCnt,
  input  logic [ETU_W-1:0] etuCnt,
  input  logic             txBitLevel,
  input  logic             rxParityOk,
  output dpStrobes_t       stb,
  output logic             busy,
  output logic             lineLow,
  output logic             errRecv,
  output logic             parityErr,
  output logic             rxFull,
  output logic             txEnd,
  output logic             irqErr,
  output logic             irqTxEnd,
  output logic             irqRx
);

  localparam int HALF    = OVS / 2;
  localparam int ERR_ETU = 11;                  // transmitter error sample point
  localparam int RX_LAST = 11;                  // receiver frees up after this ETU
  localparam int TX_LAST = ERR_ETU + GUARD_ETU; // last ETU of a transmit slot

  linkState_e state, stateNext;
  logic retry, errDrive;
  logic atMid, atLastSub;
  logic errSet, txEndSet, txEndClr, parSet, rxSet, retrySet, retryClr, errDriveSet;

  assign atMid     = sampleTick && (subCnt == SUB_W'(HALF));
  assign atLastSub = sampleTick && (subCnt == SUB_W'(OVS - 1));

  always_comb begin
    stb         = '0;
    stateNext   = state;
    errSet      = 1'b0;
    txEndSet    = 1'b0;
    txEndClr    = 1'b0;
    parSet      = 1'b0;
    rxSet       = 1'b0;
    retrySet    = 1'b0;
    retryClr    = 1'b0;
    errDriveSet = 1'b0;
    stb.cntStep = sampleTick && (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (txMode && txStart) begin
          stb.loadTx   = 1'b1;
          stb.cntClear = 1'b1;
          txEndClr     = 1'b1;
          stateNext    = ST_TX;
        end else if (!txMode && sampleTick && !lineIn) begin
          stb.cntClear = 1'b1;
          stateNext    = ST_RX;
        end
      end
      ST_TX: begin
        if (sampleTick && etuCnt == ETU_W'(ERR_ETU) && subCnt == '0 && !lineIn) begin
          errSet   = 1'b1;
          retrySet = 1'b1;
        end
        if (atLastSub && etuCnt == ETU_W'(TX_LAST)) begin
          stb.cntClear = 1'b1;
          retryClr     = 1'b1;
          if (!retry) begin
            txEndSet  = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_RX: begin
        if (atMid && etuCnt == '0 && lineIn) stateNext = ST_IDLE;
        if (atMid && etuCnt >= ETU_W'(1) && etuCnt <= ETU_W'(8)) stb.capBit = 1'b1;
        if (atMid && etuCnt == ETU_W'(9)) begin
          if (rxParityOk) begin
            stb.commitRx = 1'b1;
            rxSet        = 1'b1;
          end else begin
            parSet      = 1'b1;
            errDriveSet = 1'b1;
          end
        end
        if (atLastSub && etuCnt == ETU_W'(RX_LAST)) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      retry     <= 1'b0;
      errDrive  <= 1'b0;
      errRecv   <= 1'b0;
      parityErr <= 1'b0;
      rxFull    <= 1'b0;
      txEnd     <= 1'b0;
    end else begin
      state <= stateNext;
      if (retrySet)      retry <= 1'b1;
      else if (retryClr) retry <= 1'b0;
      if (state == ST_IDLE)  errDrive <= 1'b0;
      else if (errDriveSet)  errDrive <= 1'b1;
      if (errSet)          errRecv <= 1'b1;
      else if (clrErrRecv) errRecv <= 1'b0;
      if (parSet)            parityErr <= 1'b1;
      else if (clrParityErr) parityErr <= 1'b0;
      if (rxSet)          rxFull <= 1'b1;
      else if (clrRxFull) rxFull <= 1'b0;
      if (txEndSet)      txEnd <= 1'b1;
      else if (txEndClr) txEnd <= 1'b0;
    end
  end

  // open-drain driver: low or released, never high
  always_comb begin
    case (state)
      ST_TX:   lineLow = !txBitLevel;
      ST_RX:   lineLow = errDrive &&
                         ((etuCnt == ETU_W'(10) && subCnt >= SUB_W'(HALF)) ||
                          (etuCnt == ETU_W'(11) && subCnt <  SUB_W'(HALF)));
      default: lineLow = 1'b0;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign irqErr   = ieErr && (errRecv || parityErr);
  assign irqTxEnd = ieTxEnd && txEnd;
  assign irqRx    = ieRx && rxFull;

endmodule

// File: rtl/card_link_xcvr.sv
module card_link_xcvr
  import card_link_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int GUARD_ETU = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       txMode,
  input  logic       txStart,
  input  logic [7:0] txData,
  output logic [7:0] rxData,
  output logic       busy,
  input  logic       lineIn,
  output logic       lineLow,
  input  logic       clrErrRecv,
  input  logic       clrParityErr,
  input  logic       clrRxFull,
  output logic       errRecv,
  output logic       parityErr,
  output logic       rxFull,
  output logic       txEnd,
  input  logic       ieErr,
  input  logic       ieTxEnd,
  input  logic       ieRx,
  output logic       irqErr,
  output logic       irqTxEnd,
  output logic       irqRx
);

  localparam int SUB_W = $clog2(OVS);
  localparam int ETU_W = $clog2(11 + GUARD_ETU + 1);

  dpStrobes_t       stb;
  logic [SUB_W-1:0] subCnt;
  logic [ETU_W-1:0] etuCnt;
  logic             txBitLevel, rxParityOk;

  card_link_dp #(.OVS(OVS), .ETU_W(ETU_W), .SUB_W(SUB_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData), .lineIn(lineIn),
    .subCnt(subCnt), .etuCnt(etuCnt), .txBitLevel(txBitLevel),
    .rxParityOk(rxParityOk), .rxData(rxData)
  );

  card_link_ctrl #(.OVS(OVS), .GUARD_ETU(GUARD_ETU), .ETU_W(ETU_W), .SUB_W(SUB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .txMode(txMode),
    .txStart(txStart), .lineIn(lineIn), .clrErrRecv(clrErrRecv),
    .clrParityErr(clrParityErr), .clrRxFull(clrRxFull), .ieErr(ieErr),
    .ieTxEnd(ieTxEnd), .ieRx(ieRx), .subCnt(subCnt), .etuCnt(etuCnt),
    .txBitLevel(txBitLevel), .rxParityOk(rxParityOk), .stb(stb), .busy(busy),
    .lineLow(lineLow), .errRecv(errRecv), .parityErr(parityErr),
    .rxFull(rxFull), .txEnd(txEnd), .irqErr(irqErr), .irqTxEnd(irqTxEnd),
    .irqRx(irqRx)
  );

endmodule

// File: rtl/card_link_chk.sv
module card_link_chk (
  input logic clk,
  input logic rstN,
  input logic txMode,
  input logic txStart,
  input logic busy,
  input logic lineLow,
  input logic clrErrRecv,
  input logic errRecv,
  input logic parityErr,
  input logic rxFull,
  input logic txEnd,
  input logic irqErr
);

  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineLow);

  a_r5_start_clears_end: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && txMode && !busy) |=> (busy && !txEnd));

  a_r5_end_at_slot_close: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> (!busy && $past(busy)));

  a_r4_no_end_on_error: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errRecv) |-> (busy && !txEnd));

  a_r6_clear_err: assert property (@(posedge clk) disable iff (!rstN)
    (clrErrRecv && !busy) |=> !errRecv);

  a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    irqErr |-> (errRecv || parityErr));

  a_r8_full_or_parity: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> !$rose(parityErr));

endmodule

bind card_link_xcvr card_link_chk u_chk (.*);

// File: tb/test_card_link_xcvr.sv
module test_card_link_xcvr;

  localparam int OVS  = 16;
  localparam int HALF = OVS / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickDiv = 1'b0;
  logic       sampleTick;
  logic       txMode = 1'b1, txStart = 1'b0;
  logic [7:0] txData = '0;
  logic [7:0] rxData;
  logic       busy, lineIn, lineLow, cardLow = 1'b0;
  logic       clrErrRecv = 1'b0, clrParityErr = 1'b0, clrRxFull = 1'b0;
  logic       errRecv, parityErr, rxFull, txEnd;
  logic       ieErr = 1'b1, ieTxEnd = 1'b1, ieRx = 1'b1;
  logic       irqErr, irqTxEnd, irqRx;
  int         tickCount = 0;
  int         nChecks = 0, nFails = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  always_ff @(posedge clk) begin
    tickDiv <= ~tickDiv;
    if (sampleTick) tickCount <= tickCount + 1;
  end
  assign sampleTick = tickDiv;
  assign lineIn = !(lineLow || cardLow);   // wired open-drain line

  card_link_xcvr i_card_link_xcvr (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .txMode(txMode),
    .txStart(txStart), .txData(txData), .rxData(rxData), .busy(busy),
    .lineIn(lineIn), .lineLow(lineLow), .clrErrRecv(clrErrRecv),
    .clrParityErr(clrParityErr), .clrRxFull(clrRxFull), .errRecv(errRecv),
    .parityErr(parityErr), .rxFull(rxFull), .txEnd(txEnd), .ieErr(ieErr),
    .ieTxEnd(ieTxEnd), .ieRx(ieRx), .irqErr(irqErr), .irqTxEnd(irqTxEnd),
    .irqRx(irqRx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!sampleTick) @(negedge clk);
    end
  endtask

  task automatic hostSend(input logic [7:0] d);
    @(negedge clk);
    txData  = d;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
  endtask

  task automatic pulseClear(input int which);
    @(negedge clk);
    clrErrRecv   = (which == 0);
    clrParityErr = (which == 1);
    clrRxFull    = (which == 2);
    @(negedge clk);
    clrErrRecv = 1'b0; clrParityErr = 1'b0; clrRxFull = 1'b0;
  endtask

  // card side receiving from the block; optionally answers with an error signal
  task automatic cardReceive(input logic injectErr, output logic [9:0] bits, output int stamp);
    int waitCnt = 0;
    @(negedge clk);
    while (lineIn && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    stamp = tickCount;
    waitTicks(HALF);
    bits[0] = lineIn;
    for (int k = 1; k < 10; k++) begin
      waitTicks(OVS);
      bits[k] = lineIn;
    end
    if (injectErr) begin
      waitTicks(OVS);
      cardLow = 1'b1;
      waitTicks(OVS);
      cardLow = 1'b0;
    end
  endtask

  // card side sending to the block, then watching the error window
  task automatic cardSend(input logic [7:0] d, input logic flip, input string req);
    logic [9:0] f;
    f = {(^d) ^ flip, d, 1'b0};
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      cardLow = !f[k];
      waitTicks(OVS);
    end
    cardLow = 1'b0;
    waitTicks(OVS / 4);
    check(lineLow == 1'b0, {req, " line free before window"}, lineLow, 0);
    waitTicks(OVS - OVS / 4);
    check(lineLow == flip, {req, " error signal in window"}, lineLow, flip);
    waitTicks(OVS + HALF);
    check(lineLow == 1'b0 && busy == 1'b0, {req, " released and idle after window"}, {lineLow, busy}, 0);
  endtask

  task automatic testReset();
    check({busy, lineLow, errRecv, parityErr, rxFull, txEnd} == '0, "R9 reset state",
          {busy, lineLow, errRecv, parityErr, rxFull, txEnd}, 0);
    check({irqErr, irqTxEnd, irqRx} == '0, "R9 reset irqs", {irqErr, irqTxEnd, irqRx}, 0);
  endtask

  task automatic testTxClean();
    logic [9:0] bits;
    int st;
    txMode = 1'b1;
    hostSend(8'hA5);
    cardReceive(1'b0, bits, st);
    check(bits[0] == 1'b0, "R1 start bit low", bits[0], 0);
    check(bits[8:1] == 8'hA5, "R1 data order", bits[8:1], 8'hA5);
    check(bits[9] == ^8'hA5, "R2 even parity sent", bits[9], ^8'hA5);
    waitTicks(3 * OVS + HALF);
    check(txEnd == 1'b0 && busy == 1'b1, "R5 no end before guard", {txEnd, busy}, 2'b01);
    waitTicks(OVS + 2);
    check(txEnd == 1'b1 && busy == 1'b0, "R5 end after clean char", {txEnd, busy}, 2'b10);
    check(errRecv == 1'b0, "R5 no error flag", errRecv, 0);
    check(irqTxEnd == 1'b1, "R5 irq enabled", irqTxEnd, 1);
    @(negedge clk); ieTxEnd = 1'b0; #1;
    check(irqTxEnd == 1'b0, "R5 irq masked", irqTxEnd, 0);
    ieTxEnd = 1'b1;
  endtask

  task automatic testTxRetry();
    logic [9:0] b1, b2;
    int s1, s2;
    hostSend(8'h3C);
    cardReceive(1'b1, b1, s1);
    check(errRecv == 1'b1, "R3 error seen", errRecv, 1);
    check(irqErr == 1'b1, "R3 error irq", irqErr, 1);
    check(txEnd == 1'b0, "R4 no end on errored char", txEnd, 0);
    cardReceive(1'b0, b2, s2);
    check(b2 == b1 && b2[8:1] == 8'h3C, "R4 same char resent", b2, b1);
    check((s2 - s1) >= 14 * OVS - 2 && (s2 - s1) <= 14 * OVS + 2, "R4 resend spacing", s2 - s1, 14 * OVS);
    waitTicks(4 * OVS + HALF + 2);
    check(txEnd == 1'b1 && busy == 1'b0, "R5 end after resend", {txEnd, busy}, 2'b10);
    pulseClear(0);
    check(errRecv == 1'b0 && irqErr == 1'b0, "R6 errRecv cleared", {errRecv, irqErr}, 0);
  endtask

  task automatic testTxBusyIgnore();
    logic [9:0] bits;
    int st;
    hostSend(8'h11);
    fork
      cardReceive(1'b0, bits, st);
      begin waitTicks(3 * OVS); hostSend(8'hFF); end
    join
    check(bits[8:1] == 8'h11, "R9 start ignored while busy", bits[8:1], 8'h11);
    waitTicks(4 * OVS + HALF + 2);
    check(txEnd == 1'b1 && busy == 1'b0, "R5 end single char", {txEnd, busy}, 2'b10);
    waitTicks(2 * OVS);
    check(busy == 1'b0 && lineLow == 1'b0, "R9 no second frame", {busy, lineLow}, 0);
  endtask

  task automatic testRx();
    txMode = 1'b0;
    @(negedge clk); txStart = 1'b1; @(negedge clk); txStart = 1'b0;
    waitTicks(2);
    check(busy == 1'b0 && lineLow == 1'b0 && txEnd == 1'b1, "R9 start ignored in receive mode",
          {busy, lineLow, txEnd}, 3'b001);
    cardSend(8'h5A, 1'b0, "R7");
    check(rxFull == 1'b1 && rxData == 8'h5A, "R7 byte received", rxData, 8'h5A);
    check(parityErr == 1'b0 && irqRx == 1'b1, "R7 no parity error, irq", {parityErr, irqRx}, 2'b01);
    pulseClear(2);
    check(rxFull == 1'b0 && irqRx == 1'b0, "R6 rxFull cleared", {rxFull, irqRx}, 0);
    waitTicks(OVS);
    cardSend(8'hC3, 1'b1, "R8");
    check(parityErr == 1'b1 && irqErr == 1'b1, "R8 parity flagged", {parityErr, irqErr}, 2'b11);
    check(rxFull == 1'b0 && rxData == 8'h5A, "R8 data kept", rxData, 8'h5A);
    pulseClear(1);
    check(parityErr == 1'b0, "R6 parityErr cleared", parityErr, 0);
    waitTicks(OVS);
    cardSend(8'hFF, 1'b0, "R2");
    check(rxFull == 1'b1 && rxData == 8'hFF && parityErr == 1'b0, "R2 even parity accepted",
          {parityErr, rxData}, 9'h0FF);
    pulseClear(2);
  endtask

  task automatic testFalseStart();
    waitTicks(OVS);
    @(negedge clk); cardLow = 1'b1;
    waitTicks(3);
    cardLow = 1'b0;
    waitTicks(OVS);
    check(busy == 1'b0, "R10 glitch dropped", busy, 0);
    check(rxFull == 1'b0 && parityErr == 1'b0, "R10 no flags", {rxFull, parityErr}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTxClean();
    testTxRetry();
    testTxBusyIgnore();
    testRx();
    testFalseStart();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule